// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the four-wire serial test port of a chip. A host clocks it with TCK, steers it through the sixteen-state test-port state machine with TMS, and moves data in on TDI and out on TDO. Both directions carry the least significant bit first. A 3-bit instruction register chooses which data path sits between TDI and TDO. The choices are a one-flop bypass path, a 10-bit debug register (8 data bits and 2 status bits), and a system-programming register whose width is a parameter.

For each of the two functional data registers there is a parallel interface toward the logic behind it. The capture inputs are loaded into the shift path in Capture-DR. The update outputs take the shifted word on the falling TCK edge in Update-DR, together with a strobe that lasts one TCK period. TDO and its output enable change only on falling TCK edges. The enable is raised only while a shift state is active, so the pad can tristate the pin at all other times.

An enable input, driven by a software control bit that resets to one, can disable the port. While it is low, the state machine and every register ignore TCK and TMS and keep their contents, and the TDO enable stays low so the pins can serve as general-purpose I/O. The port is usable straight out of reset, in Test-Logic-Reset with the bypass instruction loaded.

Top module: `jtag_tap_port`

## Requirements
- R1: TMS and TDI are sampled on rising TCK edges, and the state follows the standard sixteen-state test-port sequence chosen by TMS alone.
- R2: Five consecutive rising TCK edges with TMS high reach Test-Logic-Reset from any state, and the active instruction becomes bypass (3'b111) on the next falling edge.
- R3: TDO and its output enable change only on falling TCK edges.
- R4: The TDO output enable is high only while the controller is in Shift-IR or Shift-DR. In every other state it is low and TDO reads 0.
- R5: Serial data moves least significant bit first in both directions, through every register.
- R6: The instruction register is 3 bits wide. Capture-IR loads 3'b101, so the low two bits are 01. The shifted code becomes active on the falling edge in Update-IR.
- R7: The codes are 3'b001 for the debug path, 3'b010 for the programming path and 3'b111 for bypass. Every other code selects bypass.
- R8: The bypass path is one flop that captures 0 in Capture-DR, so TDO repeats TDI one TCK later.
- R9: The debug register captures {data[7:0], status[1:0]}, so the two status bits leave first. On update, the upper 8 shifted bits drive the debug update data.
- R10: The programming register is PROG_W bits wide (default 16). It captures the programming capture input and updates the programming update output.
- R11: On the falling edge in Update-DR, only the selected register's update output is loaded and its strobe rises. The strobe falls on the next falling edge. Bypass and unassigned codes raise no strobe.
- R12: While port_en is low, TCK and TMS have no effect on any state, and the TDO output enable is low from the next falling edge. Raising port_en resumes from the state that was held.
- R13: Stopping TCK low for any length of time loses no state or register content.
- R14: Reset (rst_n low) places the controller in Test-Logic-Reset with bypass active, the TDO enable low and both strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with TCK |
| port_en | input | 1 | Port enable from a software bit; 0 freezes the port and releases the pins |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | TDO pad drive enable |
| ir_active | output | 3 | Instruction code currently in effect |
| dbg_cap_data | input | 8 | Debug data loaded in Capture-DR |
| dbg_cap_status | input | 2 | Debug status bits loaded in Capture-DR, shifted out first |
| dbg_upd_data | output | 8 | Debug data written in Update-DR |
| dbg_upd_stb | output | 1 | One-period debug update strobe |
| prog_cap_data | input | PROG_W | Programming word loaded in Capture-DR |
| prog_upd_data | output | PROG_W | Programming word written in Update-DR |
| prog_upd_stb | output | 1 | One-period programming update strobe |

## Verification
A wrong state in the controller shows at the ports within one TCK period. tdo_oe rises or falls on the wrong falling edge, and the captured instruction pattern or register word comes out rotated or from the wrong path during the next shift. A corrupted instruction latch shows on ir_active and in the delay that bypass adds, which is one bit. A lost or misdirected update shows in the first falling edge of Update-DR as a wrong update word or a strobe on the wrong register. A freeze failure while disabled shows as a lost bit, or a drop to bypass, once the port is enabled again in mid-shift.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'h0,
    ST_RTI    = 4'h1,
    ST_SEL_DR = 4'h2,
    ST_CAP_DR = 4'h3,
    ST_SH_DR  = 4'h4,
    ST_EX1_DR = 4'h5,
    ST_PA_DR  = 4'h6,
    ST_EX2_DR = 4'h7,
    ST_UPD_DR = 4'h8,
    ST_SEL_IR = 4'h9,
    ST_CAP_IR = 4'hA,
    ST_SH_IR  = 4'hB,
    ST_EX1_IR = 4'hC,
    ST_PA_IR  = 4'hD,
    ST_EX2_IR = 4'hE,
    ST_UPD_IR = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'd0,
    PATH_DEBUG  = 2'd1,
    PATH_PROG   = 2'd2
  } dr_path_e;

  localparam int unsigned IR_W = 3;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b101;
  localparam logic [IR_W-1:0] OP_DEBUG   = 3'b001;
  localparam logic [IR_W-1:0] OP_PROG    = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

  function automatic dr_path_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_DEBUG: decode_op = PATH_DEBUG;
      OP_PROG:  decode_op = PATH_PROG;
      default:  decode_op = PATH_BYPASS;
    endcase
  endfunction

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_TLR:    tap_next = m ? ST_TLR    : ST_RTI;
      ST_RTI:    tap_next = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: tap_next = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  tap_next = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: tap_next = m ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  tap_next = m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: tap_next = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: tap_next = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: tap_next = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  tap_next = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: tap_next = m ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  tap_next = m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: tap_next = m ? ST_UPD_IR : ST_SH_IR;
      default:   tap_next = m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (en) state_d = tap_next(state_q, tms);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // run of TMS-high edges, saturating at five, for the reset-path check
  logic [2:0] ones_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)  ones_run <= 3'd0;
    else if (en) ones_run <= !tms ? 3'd0 : (ones_run == 3'd5) ? 3'd5 : ones_run + 3'd1;
  end

  assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_run == 3'd5) |-> (state_q == ST_TLR))
    else $error("five TMS-high edges did not reach Test-Logic-Reset");

  assert_frozen_when_off_R12: assert property (@(posedge tck) disable iff (!rst_n)
    !en |=> $stable(state_q))
    else $error("state moved while the port was disabled");

  assert_rti_follows_tlr_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (en && state_q == ST_TLR && !tms) |=> (state_q == ST_RTI))
    else $error("Test-Logic-Reset with TMS low did not go to Run-Test/Idle");

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            en,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic            ir_lsb,
  output logic [IR_W-1:0] instr
);

  logic [IR_W-1:0] sh_q, sh_d;
  logic [IR_W-1:0] instr_q, instr_d;

  always_comb begin
    sh_d = sh_q;
    if (en) begin
      if (state == ST_CAP_IR)     sh_d = IR_CAPTURE;
      else if (state == ST_SH_IR) sh_d = {tdi, sh_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sh_q <= OP_BYPASS;
    else        sh_q <= sh_d;
  end

  always_comb begin
    instr_d = instr_q;
    if (en) begin
      if (state == ST_TLR)         instr_d = OP_BYPASS;
      else if (state == ST_UPD_IR) instr_d = sh_q;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) instr_q <= OP_BYPASS;
    else        instr_q <= instr_d;
  end

  assign ir_lsb = sh_q[0];
  assign instr  = instr_q;

  assert_ir_capture_pattern_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (en && state == ST_CAP_IR) |=> (sh_q[1:0] == 2'b01))
    else $error("Capture-IR did not load the fixed pattern");

  assert_tlr_loads_bypass_R2: assert property (@(negedge tck) disable iff (!rst_n)
    (en && state == ST_TLR) |=> (instr_q == OP_BYPASS))
    else $error("Test-Logic-Reset did not load bypass");

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned UPD_LO = 0,
  localparam int unsigned UW    = W - UPD_LO
) (
  input  logic          tck,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  tap_state_e    state,
  input  logic          tdi,
  input  logic [W-1:0]  cap_val,
  output logic          dr_lsb,
  output logic [UW-1:0] upd_val,
  output logic          upd_stb
);

  logic [W-1:0]  sh_q, sh_d, sh_shifted;
  logic [UW-1:0] upd_q, upd_d;
  logic          stb_q, stb_d;
  logic          act;

  assign act = en && sel;

  generate
    if (W == 1) begin : g_one
      assign sh_shifted = tdi;
    end else begin : g_many
      assign sh_shifted = {tdi, sh_q[W-1:1]};
    end
  endgenerate

  always_comb begin
    sh_d = sh_q;
    if (act) begin
      if (state == ST_CAP_DR)     sh_d = cap_val;
      else if (state == ST_SH_DR) sh_d = sh_shifted;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    stb_d = act && (state == ST_UPD_DR);
    upd_d = stb_d ? sh_q[W-1:UPD_LO] : upd_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= '0;
      stb_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
      stb_q <= stb_d;
    end
  end

  assign dr_lsb  = sh_q[0];
  assign upd_val = upd_q;
  assign upd_stb = stb_q;

  assert_strobe_one_period_R11: assert property (@(negedge tck) disable iff (!rst_n)
    stb_q |=> !stb_q)
    else $error("update strobe lasted more than one period");

  assert_capture_loads_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (act && state == ST_CAP_DR) |=> (sh_q == $past(cap_val)))
    else $error("Capture-DR did not load the capture word");

endmodule

// File: rtl/jtag_tap_port.sv
`timescale 1ns/1ps
module jtag_tap_port
  import jtag_tap_pkg::*;
#(
  parameter int unsigned PROG_W     = 16,
  parameter int unsigned DBG_DATA_W = 8,
  parameter int unsigned DBG_STAT_W = 2,
  localparam int unsigned DBG_W     = DBG_DATA_W + DBG_STAT_W
) (
  input  logic                  tck,
  input  logic                  rst_n,
  input  logic                  port_en,
  input  logic                  tms,
  input  logic                  tdi,
  output logic                  tdo,
  output logic                  tdo_oe,
  output logic [IR_W-1:0]       ir_active,
  input  logic [DBG_DATA_W-1:0] dbg_cap_data,
  input  logic [DBG_STAT_W-1:0] dbg_cap_status,
  output logic [DBG_DATA_W-1:0] dbg_upd_data,
  output logic                  dbg_upd_stb,
  input  logic [PROG_W-1:0]     prog_cap_data,
  output logic [PROG_W-1:0]     prog_upd_data,
  output logic                  prog_upd_stb
);

  // reset: asserted at once, released on a rising TCK edge
  logic rst_meta, rst_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  tap_state_e      state;
  logic [IR_W-1:0] instr;
  logic            ir_lsb;
  dr_path_e        path;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_q),
    .en    (port_en),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck    (tck),
    .rst_n  (rst_q),
    .en     (port_en),
    .state  (state),
    .tdi    (tdi),
    .ir_lsb (ir_lsb),
    .instr  (instr)
  );

  assign path      = decode_op(instr);
  assign ir_active = instr;

  // bypass path: a single flop
  logic byp_q, byp_d;
  always_comb begin
    byp_d = byp_q;
    if (port_en && path == PATH_BYPASS) begin
      if (state == ST_CAP_DR)     byp_d = 1'b0;
      else if (state == ST_SH_DR) byp_d = tdi;
    end
  end
  always_ff @(posedge tck or negedge rst_q) begin
    if (!rst_q) byp_q <= 1'b0;
    else        byp_q <= byp_d;
  end

  logic dbg_lsb, prog_lsb;

  tap_dr #(.W(DBG_W), .UPD_LO(DBG_STAT_W)) u_dbg (
    .tck     (tck),
    .rst_n   (rst_q),
    .en      (port_en),
    .sel     (path == PATH_DEBUG),
    .state   (state),
    .tdi     (tdi),
    .cap_val ({dbg_cap_data, dbg_cap_status}),
    .dr_lsb  (dbg_lsb),
    .upd_val (dbg_upd_data),
    .upd_stb (dbg_upd_stb)
  );

  tap_dr #(.W(PROG_W), .UPD_LO(0)) u_prog (
    .tck     (tck),
    .rst_n   (rst_q),
    .en      (port_en),
    .sel     (path == PATH_PROG),
    .state   (state),
    .tdi     (tdi),
    .cap_val (prog_cap_data),
    .dr_lsb  (prog_lsb),
    .upd_val (prog_upd_data),
    .upd_stb (prog_upd_stb)
  );

  // output stage on falling TCK
  logic shifting, out_bit;
  logic tdo_q, tdo_d, oe_q, oe_d;

  assign shifting = (state == ST_SH_IR) || (state == ST_SH_DR);

  always_comb begin
    if (state == ST_SH_IR) out_bit = ir_lsb;
    else begin
      case (path)
        PATH_DEBUG: out_bit = dbg_lsb;
        PATH_PROG:  out_bit = prog_lsb;
        default:    out_bit = byp_q;
      endcase
    end
    oe_d  = port_en && shifting;
    tdo_d = oe_d && out_bit;
  end

  always_ff @(negedge tck or negedge rst_q) begin
    if (!rst_q) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  assert_oe_only_shifting_R4: assert property (@(posedge tck) disable iff (!rst_q)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR))
    else $error("TDO enabled outside a shift state");

  assert_tdo_low_when_off_R4: assert property (@(posedge tck) disable iff (!rst_q)
    !tdo_oe |-> !tdo)
    else $error("TDO not 0 while undriven");

  assert_oe_drops_disabled_R12: assert property (@(negedge tck) disable iff (!rst_q)
    !port_en |=> !tdo_oe)
    else $error("TDO enable stayed high with the port disabled");

  assert_one_strobe_R11: assert property (@(negedge tck) disable iff (!rst_q)
    $countones({dbg_upd_stb, prog_upd_stb}) <= 1)
    else $error("two update strobes at once");

endmodule

// File: tb/sim_jtag_tap_port.sv
`timescale 1ns/1ps
module sim_jtag_tap_port;

  localparam int PW = 16;

  logic tck = 1'b0;
  logic run = 1'b1;
  always begin
    #2.5;
    if (run) tck = ~tck;
  end

  logic rst_n, port_en, tms, tdi;
  logic tdo, tdo_oe;
  logic [2:0] ir_active;
  logic [7:0] dbg_cap_data, dbg_upd_data;
  logic [1:0] dbg_cap_status;
  logic dbg_upd_stb, prog_upd_stb;
  logic [PW-1:0] prog_cap_data, prog_upd_data;

  jtag_tap_port #(.PROG_W(PW)) u0 (
    .tck(tck), .rst_n(rst_n), .port_en(port_en), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .ir_active(ir_active),
    .dbg_cap_data(dbg_cap_data), .dbg_cap_status(dbg_cap_status),
    .dbg_upd_data(dbg_upd_data), .dbg_upd_stb(dbg_upd_stb),
    .prog_cap_data(prog_cap_data), .prog_upd_data(prog_upd_data),
    .prog_upd_stb(prog_upd_stb)
  );

  int checks = 0;
  int fails  = 0;
  int r3_bad = 0;
  logic tdo_rise, oe_rise;

  // R3: outputs must not move around the rising edge
  always @(posedge tck) begin
    tdo_rise = tdo;
    oe_rise  = tdo_oe;
    #1;
    if (tdo !== tdo_rise || tdo_oe !== oe_rise) r3_bad++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic so, output logic oe);
    @(negedge tck);
    #1;
    so  = tdo;
    oe  = tdo_oe;
    tms = m;
    tdi = d;
  endtask

  task automatic idle_from_any();
    logic so, oe;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap, output logic oe_all);
    logic so, oe;
    oe_all = 1'b1;
    step(1'b1, 1'b0, so, oe);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], so, oe);
      cap[i] = so;
      oe_all = oe_all & oe;
    end
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout, output logic oe_all);
    logic so, oe;
    dout = '0;
    oe_all = 1'b1;
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], so, oe);
      dout[i] = so;
      oe_all = oe_all & oe;
    end
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
  endtask

  task automatic t_reset();
    chk("R14", "instruction after reset", ir_active, 3'b111);
    chk("R14", "tdo_oe after reset", tdo_oe, 1'b0);
    chk("R14", "strobes after reset", {dbg_upd_stb, prog_upd_stb}, 2'b00);
  endtask

  task automatic t_ir_capture();
    logic [2:0] cap;
    logic oe_all, so, oe;
    idle_from_any();
    chk("R4", "oe in Run-Test/Idle", tdo_oe, 1'b0);
    load_ir(3'b001, cap, oe_all);
    chk("R6", "Capture-IR pattern out LSB first (R5)", cap, 3'b101);
    chk("R4", "oe during Shift-IR", oe_all, 1'b1);
    chk("R6", "instruction after Update-IR", ir_active, 3'b001);
    step(1'b0, 1'b0, so, oe);
    chk("R4", "oe after leaving shift", oe, 1'b0);
  endtask

  task automatic t_bypass();
    logic [2:0] cap;
    logic [31:0] o;
    logic oe_all;
    logic [7:0] prev;
    prev = dbg_upd_data;
    load_ir(3'b111, cap, oe_all);
    shift_dr(8, 32'hA5, o, oe_all);
    chk("R8", "bypass delays TDI by one", o[7:0], 8'h4A);
    chk("R11", "no strobe for bypass", {dbg_upd_stb, prog_upd_stb}, 2'b00);
    load_ir(3'b100, cap, oe_all);
    chk("R7", "unassigned code held", ir_active, 3'b100);
    shift_dr(8, 32'h3C, o, oe_all);
    chk("R7", "unassigned code acts as bypass", o[7:0], 8'h78);
    chk("R11", "no strobe for unassigned", {dbg_upd_stb, prog_upd_stb}, 2'b00);
    chk("R11", "debug update untouched", dbg_upd_data, prev);
  endtask

  task automatic t_debug();
    logic [2:0] cap;
    logic [31:0] o;
    logic oe_all, so, oe;
    dbg_cap_data = 8'h3C;
    dbg_cap_status = 2'b10;
    load_ir(3'b001, cap, oe_all);
    shift_dr(10, {22'd0, 8'h96, 2'b01}, o, oe_all);
    chk("R9", "status bits leave first", o[1:0], 2'b10);
    chk("R9", "debug data after status (R5)", o[9:2], 8'h3C);
    chk("R4", "oe during Shift-DR", oe_all, 1'b1);
    chk("R11", "debug strobe in Update-DR", {dbg_upd_stb, prog_upd_stb}, 2'b10);
    chk("R9", "debug update data", dbg_upd_data, 8'h96);
    step(1'b0, 1'b0, so, oe);
    chk("R11", "debug strobe one period", dbg_upd_stb, 1'b0);
  endtask

  task automatic t_prog();
    logic [2:0] cap;
    logic [31:0] o;
    logic oe_all, so, oe;
    prog_cap_data = 16'hBEEF;
    load_ir(3'b010, cap, oe_all);
    shift_dr(PW, 32'h1234, o, oe_all);
    chk("R10", "programming capture word", o[15:0], 16'hBEEF);
    chk("R11", "programming strobe only", {dbg_upd_stb, prog_upd_stb}, 2'b01);
    chk("R10", "programming update word", prog_upd_data, 16'h1234);
    step(1'b0, 1'b0, so, oe);
    chk("R11", "programming strobe one period", prog_upd_stb, 1'b0);
  endtask

  task automatic t_five_ones();
    logic [2:0] cap;
    logic [31:0] o;
    logic oe_all, so, oe;
    load_ir(3'b001, cap, oe_all);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b1, so, oe);
    step(1'b0, 1'b1, so, oe);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, so, oe);
    chk("R1", "debug held until reset state reached", ir_active, 3'b001);
    step(1'b0, 1'b0, so, oe);
    chk("R2", "five TMS-high edges load bypass", ir_active, 3'b111);
    shift_dr(4, 32'hF, o, oe_all);
    chk("R2", "bypass path after reset walk", o[3:0], 4'hE);
  endtask

  task automatic t_disable();
    logic [2:0] cap;
    logic [9:0] o;
    logic oe_all, so, oe, off_ok;
    dbg_cap_data = 8'h55;
    dbg_cap_status = 2'b01;
    load_ir(3'b001, cap, oe_all);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b1, so, oe);
      o[i] = so;
    end
    step(1'b0, 1'b1, so, oe);
    o[4] = so;
    port_en = 1'b0;
    off_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, so, oe);
      off_ok = off_ok & !oe & !so;
    end
    step(1'b0, 1'b1, so, oe);
    off_ok = off_ok & !oe;
    port_en = 1'b1;
    chk("R12", "pins released while disabled", off_ok, 1'b1);
    oe_all = 1'b1;
    for (int i = 5; i < 10; i++) begin
      step(i == 9, 1'b1, so, oe);
      o[i] = so;
      oe_all = oe_all & oe;
    end
    chk("R12", "shift resumes after re-enable", oe_all, 1'b1);
    chk("R12", "instruction kept while disabled", ir_active, 3'b001);
    chk("R12", "register word intact across disable", o, 10'h155);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    chk("R12", "update after resumed shift", dbg_upd_data, 8'hFF);
  endtask

  task automatic t_clock_stop();
    logic [2:0] cap;
    logic [15:0] o;
    logic oe_all, so, oe, so_hold;
    prog_cap_data = 16'h0F0F;
    load_ir(3'b010, cap, oe_all);
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'(16'hA5A5 >> i), so, oe);
      o[i] = so;
    end
    so_hold = tdo;
    run = 1'b0;
    #600;
    chk("R13", "outputs hold with TCK stopped", {tdo_oe, tdo}, {1'b1, so_hold});
    run = 1'b1;
    for (int i = 8; i < 16; i++) begin
      step(i == 15, 1'(16'hA5A5 >> i), so, oe);
      o[i] = so;
    end
    step(1'b1, 1'b0, so, oe);
    step(1'b0, 1'b0, so, oe);
    chk("R13", "word out across clock stop", o, 16'h0F0F);
    chk("R13", "word in across clock stop", prog_upd_data, 16'hA5A5);
  endtask

  task automatic t_async_reset();
    logic [2:0] cap;
    logic oe_all, so, oe;
    load_ir(3'b001, cap, oe_all);
    @(negedge tck);
    rst_n = 1'b0;
    #1;
    chk("R14", "reset forces bypass", ir_active, 3'b111);
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    repeat (4) step(1'b1, 1'b0, so, oe);
    chk("R14", "oe low after reset", tdo_oe, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    port_en = 1'b1;
    tms = 1'b1;
    tdi = 1'b0;
    dbg_cap_data = 8'h00;
    dbg_cap_status = 2'b00;
    prog_cap_data = '0;
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    repeat (4) @(negedge tck);
    #1;
    t_reset();
    t_ir_capture();
    t_bypass();
    t_debug();
    t_prog();
    t_five_ones();
    idle_from_any();
    t_disable();
    idle_from_any();
    t_clock_stop();
    idle_from_any();
    t_async_reset();
    chk("R3", "outputs steady across rising edges", r3_bad, 0);
    summary();
  end

endmodule